// File: doc/BRIEF.md
# Paged Address Translator with Physical Window Port

This block sits between an 8-bit CPU with a 16-bit address bus and a large byte-addressed physical memory. The logical space is cut into sixteen 4KB pages. The top four bits of each CPU memory address pick one of sixteen page entries. The entry's 14-bit frame number then takes the place of those four bits, which gives a 26-bit physical address. Each page can point at any physical 4KB frame, and no page depends on another. At reset, the sixteen pages cover a contiguous 64KB boot region, so the CPU's first fetch lands in boot memory.

A second path reaches physical memory without touching the page map. A 26-bit pointer register and a data port sit on the CPU's I/O bus. Each I/O read or write on that data port becomes one physical memory cycle at the pointer, and the pointer then steps by one. A repeated block I/O instruction can therefore copy a run of consecutive physical bytes into or out of mapped memory. The CPU is held with a wait signal until the memory side acknowledges.

All programming is done with byte-wide I/O ports at a parameterised base:
- offset 0 selects a page entry;
- offsets 1 and 2 hold the high and low parts of the selected entry's frame;
- offsets 3 to 6 hold the four pointer bytes;
- offset 7 is the window data port.

Top module: `page_xlate_unit`

## Requirements
- R1: After reset, page i maps to frame BOOT_FRAME+i (default 0x3FF0+i), the select register reads 0, and all four pointer bytes read 0.
- R2: A CPU memory cycle (cpu_mreq high, cpu_ioreq low) presents mem_addr = {frame of page cpu_addr[15:12], cpu_addr[11:0]}, with mem_we = cpu_wr and mem_wdata = cpu_wdata.
- R3: Writing one page entry changes the translation of that page only; every other page keeps its frame.
- R4: The I/O port number is cpu_addr[7:0]. Port BASE+0 holds the 4-bit entry select in bits 3:0. BASE+1 holds frame bits 13:8 in data bits 5:0. BASE+2 holds frame bits 7:0. Each reads back what was written, with unused bits reading 0.
- R5: Ports BASE+3, +4, +5 and +6 hold pointer bits 25:24 (in data bits 1:0), 23:16, 15:8 and 7:0. Each reads back what was written.
- R6: An I/O read on BASE+7 issues a memory read at the pointer address. cpu_wait stays high until mem_ack, and cpu_rdata returns mem_rdata.
- R7: An I/O write on BASE+7 issues a memory write of cpu_wdata at the pointer address.
- R8: The pointer rises by exactly one on each completed window access. It holds its value while the access waits.
- R9: The pointer step wraps from 0x3FFFFFF to 0.
- R10: During any I/O cycle, a memory request is raised only for the window port, even if cpu_mreq is also high. Window accesses leave the page map unchanged.
- R11: I/O writes to ports outside BASE..BASE+7 change nothing, and reads of those ports return 0 without waiting.
- R12: Register port accesses (BASE+0..BASE+6) complete without asserting cpu_wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_mreq | input | 1 | CPU memory cycle request, held until not waited |
| cpu_ioreq | input | 1 | CPU I/O cycle request, held until not waited |
| cpu_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| cpu_addr | input | 16 | Logical address; bits 7:0 form the I/O port number |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | I/O read data returned to the CPU |
| cpu_wait | output | 1 | Stall request to the CPU |
| mem_req | output | 1 | Physical memory request |
| mem_we | output | 1 | Physical write enable |
| mem_addr | output | 26 | Physical byte address |
| mem_wdata | output | 8 | Physical write data |
| mem_rdata | input | 8 | Physical read data, valid with mem_ack |
| mem_ack | input | 1 | Memory completion; the cycle ends on the edge where it is high |

## Verification
The bench first checks the boot mapping, because a reset value that was off by one page would send the first fetch to the wrong frame. It then sets the pointer to its top value and makes one window access. A design that saturated, or carried into a 27th bit, would read back something other than zero after that access. Memory latency is changed between runs. This exposes a pointer that steps while cpu_wait is high, which would shift every later window address. The bench also raises a memory request together with a register I/O cycle, and writes to ports just outside the decoded range. A loose decode or a missing I/O gate would then issue a stray memory cycle or corrupt a page entry.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  // Function of a decoded I/O port; values equal the offset from the base port
  typedef enum logic [3:0] {
    FN_SEL  = 4'd0,
    FN_FHI  = 4'd1,
    FN_FLO  = 4'd2,
    FN_PTR3 = 4'd3,
    FN_PTR2 = 4'd4,
    FN_PTR1 = 4'd5,
    FN_PTR0 = 4'd6,
    FN_WIN  = 4'd7,
    FN_NONE = 4'd8
  } port_fn_e;
endpackage

// File: rtl/mmu_io_decode.sv
module mmu_io_decode
  import mmu_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] BASE_PORT = 8'hF0
) (
  input  logic              ioreq,
  input  logic [PORT_W-1:0] port,
  output port_fn_e          fn
);
  localparam int NUM_PORTS = 8;
  logic [PORT_W-1:0] offs;

  always_comb begin
    offs = port - BASE_PORT;
    fn   = FN_NONE;
    if (ioreq && (port >= BASE_PORT) && (offs < PORT_W'(NUM_PORTS))) begin
      fn = port_fn_e'(offs[3:0]);
    end
  end
endmodule

// File: rtl/mmu_page_table.sv
module mmu_page_table
  import mmu_pkg::*;
#(
  parameter int PAGE_BITS = 4,
  parameter int FRAME_W   = 14,
  parameter logic [FRAME_W-1:0] BOOT_FRAME = 14'h3FF0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  port_fn_e             fn,
  input  logic [7:0]           wdata,
  input  logic [PAGE_BITS-1:0] look_idx,
  output logic [FRAME_W-1:0]   look_frame,
  output logic [PAGE_BITS-1:0] sel_o,
  output logic [FRAME_W-1:0]   sel_frame
);
  localparam int NUM_PAGES = 1 << PAGE_BITS;

  logic [FRAME_W-1:0]   frames_q [NUM_PAGES];
  logic [FRAME_W-1:0]   frames_d [NUM_PAGES];
  logic [PAGE_BITS-1:0] sel_q, sel_d;

  // next state
  always_comb begin
    frames_d = frames_q;
    sel_d    = sel_q;
    if (wr_en) begin
      case (fn)
        FN_SEL: sel_d = wdata[PAGE_BITS-1:0];
        FN_FHI: frames_d[sel_q] = FRAME_W'({wdata, frames_q[sel_q][7:0]});
        FN_FLO: frames_d[sel_q] = FRAME_W'({frames_q[sel_q] >> 8, wdata});
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      for (int i = 0; i < NUM_PAGES; i++) begin
        frames_q[i] <= FRAME_W'(BOOT_FRAME + FRAME_W'(i));
      end
    end else if (wr_en) begin
      sel_q    <= sel_d;
      frames_q <= frames_d;
    end
  end

  assign look_frame = frames_q[look_idx];
  assign sel_o      = sel_q;
  assign sel_frame  = frames_q[sel_q];

  // R4
  flo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fn == FN_FLO) |=> (frames_q[$past(sel_q)][7:0] == $past(wdata)));
  // R4
  sel_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fn == FN_SEL) |=> (sel_q == $past(wdata[PAGE_BITS-1:0])));
endmodule

// File: rtl/mmu_window_ptr.sv
module mmu_window_ptr
  import mmu_pkg::*;
#(
  parameter int PADDR_W = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  port_fn_e           fn,
  input  logic [7:0]         wdata,
  input  logic               adv,
  output logic [PADDR_W-1:0] ptr_o
);
  logic [PADDR_W-1:0] ptr_q, ptr_d;
  logic [31:0]        pad;
  logic               en;

  // next state
  always_comb begin
    pad = 32'(ptr_q);
    if (wr_en) begin
      case (fn)
        FN_PTR3: pad[31:24] = wdata;
        FN_PTR2: pad[23:16] = wdata;
        FN_PTR1: pad[15:8]  = wdata;
        FN_PTR0: pad[7:0]   = wdata;
        default: ;
      endcase
    end
    ptr_d = adv ? (ptr_q + 1'b1) : PADDR_W'(pad);
    en    = wr_en | adv;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

  // R8
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (ptr_q == PADDR_W'($past(ptr_q) + 1'b1)));
  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !wr_en) |=> $stable(ptr_q));
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
  import mmu_pkg::*;
#(
  parameter int LADDR_W   = 16,
  parameter int PAGE_BITS = 4,
  parameter int PADDR_W   = 26,
  parameter int PORT_W    = 8,
  parameter logic [PORT_W-1:0] BASE_PORT = 8'hF0,
  parameter logic [PADDR_W-LADDR_W+PAGE_BITS-1:0] BOOT_FRAME = 14'h3FF0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_mreq,
  input  logic               cpu_ioreq,
  input  logic               cpu_wr,
  input  logic [LADDR_W-1:0] cpu_addr,
  input  logic [7:0]         cpu_wdata,
  output logic [7:0]         cpu_rdata,
  output logic               cpu_wait,
  output logic               mem_req,
  output logic               mem_we,
  output logic [PADDR_W-1:0] mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  input  logic               mem_ack
);
  localparam int OFFS_W  = LADDR_W - PAGE_BITS;
  localparam int FRAME_W = PADDR_W - OFFS_W;

  port_fn_e             fn;
  logic                 win_req, mem_path, io_done, reg_wr, adv;
  logic [FRAME_W-1:0]   look_frame, sel_frame;
  logic [PAGE_BITS-1:0] sel;
  logic [PADDR_W-1:0]   ptr;
  logic [31:0]          ptr_pad, frame_pad;

  mmu_io_decode #(.PORT_W(PORT_W), .BASE_PORT(BASE_PORT)) dec_i (
    .ioreq (cpu_ioreq),
    .port  (cpu_addr[PORT_W-1:0]),
    .fn    (fn)
  );

  mmu_page_table #(.PAGE_BITS(PAGE_BITS), .FRAME_W(FRAME_W), .BOOT_FRAME(BOOT_FRAME)) tbl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .fn         (fn),
    .wdata      (cpu_wdata),
    .look_idx   (cpu_addr[LADDR_W-1:OFFS_W]),
    .look_frame (look_frame),
    .sel_o      (sel),
    .sel_frame  (sel_frame)
  );

  mmu_window_ptr #(.PADDR_W(PADDR_W)) ptr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr),
    .fn    (fn),
    .wdata (cpu_wdata),
    .adv   (adv),
    .ptr_o (ptr)
  );

  // request steering
  always_comb begin
    win_req   = (fn == FN_WIN);
    mem_path  = cpu_mreq && !cpu_ioreq;
    mem_req   = win_req || mem_path;
    cpu_wait  = mem_req && !mem_ack;
    io_done   = cpu_ioreq && !cpu_wait;
    reg_wr    = io_done && cpu_wr;
    adv       = win_req && mem_ack;
    mem_we    = cpu_wr;
    mem_wdata = cpu_wdata;
    mem_addr  = win_req ? ptr : {look_frame, cpu_addr[OFFS_W-1:0]};
  end

  // I/O read-back
  always_comb begin
    ptr_pad   = 32'(ptr);
    frame_pad = 32'(sel_frame);
    case (fn)
      FN_SEL:  cpu_rdata = 8'(sel);
      FN_FHI:  cpu_rdata = frame_pad[15:8];
      FN_FLO:  cpu_rdata = frame_pad[7:0];
      FN_PTR3: cpu_rdata = ptr_pad[31:24];
      FN_PTR2: cpu_rdata = ptr_pad[23:16];
      FN_PTR1: cpu_rdata = ptr_pad[15:8];
      FN_PTR0: cpu_rdata = ptr_pad[7:0];
      FN_WIN:  cpu_rdata = mem_rdata;
      default: cpu_rdata = 8'h00;
    endcase
  end

  // R12
  reg_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ioreq && fn != FN_WIN) |-> !cpu_wait);
  // R10
  io_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ioreq && fn != FN_WIN) |-> !mem_req);
  // R6
  win_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_WIN && !mem_ack) |-> cpu_wait);
endmodule

// File: tb/page_xlate_unit_tb_top.sv
`timescale 1ns/1ps
module page_xlate_unit_tb_top;
  localparam logic [7:0]  BASE = 8'hF0;
  localparam logic [13:0] BOOT = 14'h3FF0;

  typedef struct {
    logic [25:0] addr;
    logic        we;
    logic [7:0]  data;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_mreq, cpu_ioreq, cpu_wr;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic        cpu_wait, mem_req, mem_we;
  logic [25:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        mem_ack;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int cnt = 0;
  exp_t q[$];
  logic [7:0]  bmem [logic [25:0]];
  logic [13:0] exp_frame [16];
  logic [25:0] exp_ptr;

  always #2.5 clk = ~clk;

  page_xlate_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_mreq(cpu_mreq), .cpu_ioreq(cpu_ioreq),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [25:0] a);
    if (bmem.exists(a)) return bmem[a];
    return a[7:0] ^ 8'h5A;
  endfunction

  // memory model and scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (mem_ack) begin
      mem_ack = 1'b0;
      cnt = 0;
    end else if (mem_req) begin
      if (cnt >= lat) begin
        if (q.size() == 0) begin
          check(1'b0, "R10 stray request", 32'(mem_addr), 32'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(mem_addr == e.addr, e.tag, 32'(mem_addr), 32'(e.addr));
          check(mem_we == e.we, e.tag, 32'(mem_we), 32'(e.we));
          if (e.we) check(mem_wdata == e.data, e.tag, 32'(mem_wdata), 32'(e.data));
        end
        if (mem_we) bmem[mem_addr] = mem_wdata;
        mem_rdata = model_rd(mem_addr);
        mem_ack = 1'b1;
      end else begin
        cnt++;
      end
    end
  end

  task automatic cycle(input bit io, input logic [15:0] a, input bit wr, input logic [7:0] d,
                       output logic [7:0] rd, output int waits);
    @(negedge clk);
    cpu_ioreq = io; cpu_mreq = !io; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    waits = 0;
    #1;
    while (cpu_wait) begin
      @(posedge clk); #2;
      waits++;
    end
    rd = cpu_rdata;
    @(posedge clk);
    @(negedge clk);
    cpu_ioreq = 1'b0; cpu_mreq = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] port, input logic [7:0] d);
    logic [7:0] rd; int w;
    cycle(1'b1, {8'h00, port}, 1'b1, d, rd, w);
    check(w == 0, "R12 write wait", 32'(w), 32'd0);
  endtask

  task automatic rd_reg(input logic [7:0] port, input logic [7:0] exp, input string tag);
    logic [7:0] rd; int w;
    cycle(1'b1, {8'h00, port}, 1'b0, 8'h00, rd, w);
    check(rd == exp, tag, 32'(rd), 32'(exp));
    check(w == 0, "R12 read wait", 32'(w), 32'd0);
  endtask

  task automatic set_entry(input int p, input logic [13:0] f);
    wr_reg(BASE + 8'd0, 8'(p));
    wr_reg(BASE + 8'd1, {2'b00, f[13:8]});
    wr_reg(BASE + 8'd2, f[7:0]);
    exp_frame[p] = f;
  endtask

  task automatic set_ptr(input logic [25:0] v);
    wr_reg(BASE + 8'd3, {6'b0, v[25:24]});
    wr_reg(BASE + 8'd4, v[23:16]);
    wr_reg(BASE + 8'd5, v[15:8]);
    wr_reg(BASE + 8'd6, v[7:0]);
    exp_ptr = v;
  endtask

  task automatic chk_ptr(input string tag);
    rd_reg(BASE + 8'd3, {6'b0, exp_ptr[25:24]}, tag);
    rd_reg(BASE + 8'd4, exp_ptr[23:16], tag);
    rd_reg(BASE + 8'd5, exp_ptr[15:8], tag);
    rd_reg(BASE + 8'd6, exp_ptr[7:0], tag);
  endtask

  task automatic mem_access(input logic [15:0] a, input bit wr, input logic [7:0] d, input string tag);
    exp_t e; logic [7:0] rd; int w;
    e.addr = {exp_frame[a[15:12]], a[11:0]}; e.we = wr; e.data = d; e.tag = tag;
    q.push_back(e);
    cycle(1'b0, a, wr, d, rd, w);
    check(w == lat + 1, {tag, " wait"}, 32'(w), 32'(lat + 1));
  endtask

  task automatic win_write(input logic [7:0] d);
    exp_t e; logic [7:0] rd; int w;
    e.addr = exp_ptr; e.we = 1'b1; e.data = d; e.tag = "R7 window write";
    q.push_back(e);
    cycle(1'b1, {8'h00, BASE + 8'd7}, 1'b1, d, rd, w);
    check(w == lat + 1, "R6 window wait", 32'(w), 32'(lat + 1));
    exp_ptr = exp_ptr + 26'd1;
  endtask

  task automatic win_read();
    exp_t e; logic [7:0] rd; logic [7:0] exp; int w;
    exp = model_rd(exp_ptr);
    e.addr = exp_ptr; e.we = 1'b0; e.data = 8'h00; e.tag = "R6 window read";
    q.push_back(e);
    cycle(1'b1, {8'h00, BASE + 8'd7}, 1'b0, 8'h00, rd, w);
    check(rd == exp, "R6 window data", 32'(rd), 32'(exp));
    check(w == lat + 1, "R6 window wait", 32'(w), 32'(lat + 1));
    exp_ptr = exp_ptr + 26'd1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_mreq = 1'b0; cpu_ioreq = 1'b0; cpu_wr = 1'b0;
    cpu_addr = '0; cpu_wdata = '0; mem_ack = 1'b0; mem_rdata = '0;
    for (int i = 0; i < 16; i++) exp_frame[i] = BOOT + 14'(i);
    exp_ptr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state through readback
    rd_reg(BASE + 8'd0, 8'h00, "R1 select");
    chk_ptr("R1 pointer");
    for (int i = 0; i < 16; i++) begin
      wr_reg(BASE + 8'd0, 8'(i));
      rd_reg(BASE + 8'd1, {2'b00, exp_frame[i][13:8]}, "R1 frame hi");
      rd_reg(BASE + 8'd2, exp_frame[i][7:0], "R1 frame lo");
    end
    mem_access(16'h0000, 1'b0, 8'h00, "R1 boot fetch");

    // R2 / R3 / R4: programming and translation
    lat = 2;
    set_entry(3, 14'h2A5C);
    set_entry(15, 14'h0001);
    wr_reg(BASE + 8'd0, 8'd3);
    rd_reg(BASE + 8'd0, 8'h03, "R4 select");
    rd_reg(BASE + 8'd1, 8'h2A, "R4 frame hi");
    rd_reg(BASE + 8'd2, 8'h5C, "R4 frame lo");
    mem_access(16'h3ABC, 1'b1, 8'hC3, "R2 translate write");
    mem_access(16'hF123, 1'b0, 8'h00, "R2 translate read");
    mem_access(16'h2FFF, 1'b0, 8'h00, "R3 neighbour page");
    mem_access(16'h4000, 1'b0, 8'h00, "R3 neighbour page");

    // R11: ports outside the decoded range
    wr_reg(BASE + 8'd8, 8'h07);
    wr_reg(BASE - 8'd1, 8'h0E);
    rd_reg(BASE + 8'd8, 8'h00, "R11 unclaimed read");
    rd_reg(BASE - 8'd1, 8'h00, "R11 unclaimed read");
    rd_reg(BASE + 8'd0, 8'h03, "R11 select untouched");
    rd_reg(BASE + 8'd2, 8'h5C, "R11 entry untouched");

    // R10: register I/O with memory request raised alongside
    @(negedge clk);
    cpu_ioreq = 1'b1; cpu_mreq = 1'b1; cpu_wr = 1'b0; cpu_addr = {8'h00, BASE + 8'd2};
    #1;
    check(mem_req == 1'b0, "R10 io gates memory", 32'(mem_req), 32'd0);
    check(cpu_rdata == 8'h5C, "R10 io read", 32'(cpu_rdata), 32'h5C);
    @(negedge clk);
    cpu_ioreq = 1'b0; cpu_mreq = 1'b0;

    // R5: pointer bytes
    set_ptr(26'h2345678);
    chk_ptr("R5 pointer readback");

    // R7 / R8: streaming writes, latency 0 then 3
    lat = 0;
    win_write(8'h11);
    win_write(8'h22);
    lat = 3;
    win_write(8'h33);
    chk_ptr("R8 pointer after writes");

    // R6: streaming reads of what was written, plus an untouched byte
    set_ptr(26'h2345678);
    win_read();
    lat = 1;
    win_read();
    win_read();
    win_read();
    chk_ptr("R8 pointer after reads");

    // R9: wrap at the top of the space
    set_ptr(26'h3FFFFFF);
    win_write(8'hA5);
    chk_ptr("R9 pointer wrap");
    win_read();
    set_ptr(26'h3FFFFFF);
    win_read();

    // R10: map undisturbed after window traffic
    mem_access(16'h3ABC, 1'b0, 8'h00, "R10 map kept");
    mem_access(16'h1000, 1'b0, 8'h00, "R10 map kept");
    check(q.size() == 0, "R10 scoreboard drained", 32'(q.size()), 32'd0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule